// File: doc/BRIEF.md
# Priority Sector Scrub Scheduler

This block decides which configuration sectors receive an error-check pass in each time step. Each sector is either a priority sector or a normal sector, set by a mask that is sampled when `start` is pulsed. The scheduler then sorts the sectors into two independent tracks of groups. It sizes the groups so that no more than `SMAX` sectors are checked at once, and the priority track never uses all the slots.

In each step, group k of the priority track and group k of the normal track are requested together. The scheduler holds the request vector until every requested sector has reported done. It then moves both tracks on by one group. The priority track usually has far fewer groups than the normal track, so it wraps back to its group 0 many times during one normal pass. As a result, priority sectors are visited much more often. A one-cycle pulse marks the end of each normal pass. A warning level shows when the priority track has become longer than the normal track. The check engines and the timing between passes are outside this block.

Top module: `scrub_sched`

## Requirements
- R1: After reset `sectorReq` is all zero, `prioGroup` and `normGroup` are 0, and `cycleEnd` and `overrunWarn` are 0. No request is issued until `start` is seen.
- R2: With P priority sectors and P <= SMAX-1, the priority track has exactly one group, and that group holds all P priority sectors. The normal track uses SMAX-P slots per group, and its group count is ceil(N/(SMAX-P)), where N = NUM_SECTORS-P. P=2 gives 10 normal groups.
- R3: With P > SMAX-1, the priority group count is GP = ceil(P/(SMAX-1)). The priority slots per group are ceil(P/GP). The normal slots are SMAX minus the priority slots. The normal group count is ceil(N/normal slots), with a minimum of 1 group. P=6 gives GP=2 and 12 normal groups. P=30 gives GP=8 and 1 normal group.
- R4: Within each track, sectors are placed in ascending index order. Each group is filled to its slot count before the next group starts, so only the last group may be partial.
- R5: At most SMAX request bits are high at once, and at most SMAX-1 of them belong to priority sectors.
- R6: The tracks advance on the clock edge where every requested sector has reported done, counting done pulses seen in earlier cycles of the same step. Done pulses from sectors that are not requested have no effect.
- R7: `prioGroup` counts 0..GP-1 and goes back to 0 after GP-1, whatever the value of `normGroup`.
- R8: `cycleEnd` is high for exactly the one cycle in which `normGroup` has just wrapped from its last group to 0. It is low otherwise.
- R9: `overrunWarn` is 1 exactly when GP exceeds the normal group count of the plan set by the last `start`.
- R10: The mask is sampled only in the cycle `start` is high. Later changes of `prioMask` do not change the requests.
- R11: A `start` during a pass discards the pass in progress and restarts both tracks at group 0 with the new plan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sample mask, rebuild plan, restart at group 0 |
| prioMask | input | NUM_SECTORS | 1 marks a priority sector (bit i = sector i) |
| sectorDone | input | NUM_SECTORS | Per-sector check-done pulse |
| sectorReq | output | NUM_SECTORS | Per-sector check request, held for the step |
| prioGroup | output | $clog2(NUM_SECTORS+1) | Current priority-track group |
| normGroup | output | $clog2(NUM_SECTORS+1) | Current normal-track group |
| cycleEnd | output | 1 | One-cycle pulse on normal-track wrap |
| overrunWarn | output | 1 | Priority track longer than normal track |

## Verification
The bench builds the block with its defaults, NUM_SECTORS=30 and SMAX=5. These values bring both sizing branches within reach. They also cover the edge cases of an empty priority group (P=0), a one-group normal track with the warning raised (P=30), and a 26-group normal track with one slot per group (P=4). A bench model derives the expected request vector for each step from the requirement formulas. It also drives partial and stray done pulses, changes the mask while the block runs, and restarts in the middle of a pass.

// File: rtl/scrub_sched_pkg.sv
package scrub_sched_pkg;
  typedef struct packed {
    logic load;     // sample mask and rebuild the plan
    logic advance;  // current step finished, move on
    logic active;   // schedule running, requests allowed
  } schedStrobe_t;
endpackage

// File: rtl/scrub_sched_dp.sv
module scrub_sched_dp
  import scrub_sched_pkg::*;
#(
  parameter int NUM_SECTORS = 30,
  parameter int SMAX        = 5,
  localparam int CW         = $clog2(NUM_SECTORS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  schedStrobe_t           strobe,
  input  logic [NUM_SECTORS-1:0] prioMask,
  input  logic [NUM_SECTORS-1:0] sectorDone,
  input  logic [CW-1:0]          prioGroup,
  input  logic [CW-1:0]          normGroup,
  output logic [NUM_SECTORS-1:0] sectorReq,
  output logic                   allDone,
  output logic [CW-1:0]          gpCount,
  output logic [CW-1:0]          gnCount,
  output logic                   overrunWarn
);
  // plan computation (only used on load)
  int pCnt, nCnt, gpN, psN, nsN, gnN, pFill, nFill, pGrp, nGrp;
  logic [CW-1:0] grpNext [NUM_SECTORS];

  always_comb begin
    pCnt = 0;
    for (int s = 0; s < NUM_SECTORS; s++) pCnt += int'(prioMask[s]);
    nCnt = NUM_SECTORS - pCnt;
    if (pCnt <= SMAX - 1) gpN = 1;
    else                  gpN = (pCnt + SMAX - 2) / (SMAX - 1);
    psN = (pCnt == 0) ? 0 : (pCnt + gpN - 1) / gpN;
    nsN = SMAX - psN;
    gnN = (nCnt == 0) ? 1 : (nCnt + nsN - 1) / nsN;
    pFill = 0; nFill = 0; pGrp = 0; nGrp = 0;
    for (int s = 0; s < NUM_SECTORS; s++) begin
      if (prioMask[s]) begin
        grpNext[s] = CW'(pGrp);
        pFill++;
        if (pFill == psN) begin pFill = 0; pGrp++; end
      end else begin
        grpNext[s] = CW'(nGrp);
        nFill++;
        if (nFill == nsN) begin nFill = 0; nGrp++; end
      end
    end
  end

  // latched plan
  logic [NUM_SECTORS-1:0] maskQ, doneSeen;
  logic [CW-1:0]          grpTab [NUM_SECTORS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ       <= '0;
      gpCount     <= CW'(1);
      gnCount     <= CW'(1);
      overrunWarn <= 1'b0;
      for (int s = 0; s < NUM_SECTORS; s++) grpTab[s] <= '0;
    end else if (strobe.load) begin
      maskQ       <= prioMask;
      gpCount     <= CW'(gpN);
      gnCount     <= CW'(gnN);
      overrunWarn <= (gpN > gnN);
      for (int s = 0; s < NUM_SECTORS; s++) grpTab[s] <= grpNext[s];
    end
  end

  // request vector and done collection
  always_comb begin
    for (int s = 0; s < NUM_SECTORS; s++)
      sectorReq[s] = strobe.active &&
                     (maskQ[s] ? (grpTab[s] == prioGroup) : (grpTab[s] == normGroup));
  end

  assign allDone = (((doneSeen | sectorDone) & sectorReq) == sectorReq);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.load || strobe.advance) doneSeen <= '0;
    else doneSeen <= doneSeen | (sectorDone & sectorReq);
  end

  // R5: concurrency limits of a step
  assert_req_limit_R5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(sectorReq) <= SMAX);
  assert_prio_slots_R5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(sectorReq & maskQ) <= SMAX - 1);
endmodule

// File: rtl/scrub_sched_ctrl.sv
module scrub_sched_ctrl
  import scrub_sched_pkg::*;
#(
  parameter int NUM_SECTORS = 30,
  localparam int CW         = $clog2(NUM_SECTORS + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         allDone,
  input  logic [CW-1:0] gpCount,
  input  logic [CW-1:0] gnCount,
  output schedStrobe_t strobe,
  output logic [CW-1:0] prioGroup,
  output logic [CW-1:0] normGroup,
  output logic         cycleEnd
);
  logic activeQ;
  logic prioLast, normLast;

  assign prioLast = (prioGroup == gpCount - CW'(1));
  assign normLast = (normGroup == gnCount - CW'(1));

  assign strobe.load    = start;
  assign strobe.active  = activeQ;
  assign strobe.advance = activeQ && allDone && !start;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ   <= 1'b0;
      prioGroup <= '0;
      normGroup <= '0;
      cycleEnd  <= 1'b0;
    end else if (start) begin
      activeQ   <= 1'b1;
      prioGroup <= '0;
      normGroup <= '0;
      cycleEnd  <= 1'b0;
    end else if (strobe.advance) begin
      prioGroup <= prioLast ? '0 : prioGroup + CW'(1);
      normGroup <= normLast ? '0 : normGroup + CW'(1);
      cycleEnd  <= normLast;
    end else begin
      cycleEnd  <= 1'b0;
    end
  end

  // R8: pass-end pulse only with the normal track at group 0
  assert_cycle_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    cycleEnd |-> (normGroup == '0));
  // R7: priority group stays inside its range
  assert_prio_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    activeQ |-> (prioGroup < gpCount));
  // R6: no move while a requested sector is still pending
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && !allDone && !start) |=> ($stable(prioGroup) && $stable(normGroup)));
endmodule

// File: rtl/scrub_sched.sv
module scrub_sched
  import scrub_sched_pkg::*;
#(
  parameter int NUM_SECTORS = 30,
  parameter int SMAX        = 5,
  localparam int CW         = $clog2(NUM_SECTORS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [NUM_SECTORS-1:0] prioMask,
  input  logic [NUM_SECTORS-1:0] sectorDone,
  output logic [NUM_SECTORS-1:0] sectorReq,
  output logic [CW-1:0]          prioGroup,
  output logic [CW-1:0]          normGroup,
  output logic                   cycleEnd,
  output logic                   overrunWarn
);
  schedStrobe_t strobe;
  logic         allDone;
  logic [CW-1:0] gpCount, gnCount;

  scrub_sched_ctrl #(.NUM_SECTORS(NUM_SECTORS)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .allDone(allDone),
    .gpCount(gpCount), .gnCount(gnCount), .strobe(strobe),
    .prioGroup(prioGroup), .normGroup(normGroup), .cycleEnd(cycleEnd)
  );

  scrub_sched_dp #(.NUM_SECTORS(NUM_SECTORS), .SMAX(SMAX)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .prioMask(prioMask),
    .sectorDone(sectorDone), .prioGroup(prioGroup), .normGroup(normGroup),
    .sectorReq(sectorReq), .allDone(allDone), .gpCount(gpCount),
    .gnCount(gnCount), .overrunWarn(overrunWarn)
  );
endmodule

// File: tb/scrub_sched_tb_top.sv
`timescale 1ns/1ps
module scrub_sched_tb_top;
  localparam int NS = 30;
  localparam int SM = 5;
  localparam int CW = $clog2(NS + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [NS-1:0] prioMask = '0;
  logic [NS-1:0] sectorDone = '0;
  logic [NS-1:0] sectorReq;
  logic [CW-1:0] prioGroup, normGroup;
  logic cycleEnd, overrunWarn;

  always #4 clk = ~clk;  // 125 MHz

  scrub_sched #(.NUM_SECTORS(NS), .SMAX(SM)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .prioMask(prioMask),
    .sectorDone(sectorDone), .sectorReq(sectorReq), .prioGroup(prioGroup),
    .normGroup(normGroup), .cycleEnd(cycleEnd), .overrunWarn(overrunWarn)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  // bench model of the plan
  logic [NS-1:0] lm;
  int mGp, mGn, mPs, mNs, epg, eng;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic setModel(logic [NS-1:0] m);
    int p, n;
    p = $countones(m); n = NS - p;
    lm  = m;
    mGp = (p <= SM - 1) ? 1 : (p + SM - 2) / (SM - 1);
    mPs = (p == 0) ? 0 : (p + mGp - 1) / mGp;
    mNs = SM - mPs;
    mGn = (n == 0) ? 1 : (n + mNs - 1) / mNs;
    epg = 0; eng = 0;
  endtask

  function automatic logic [NS-1:0] expReq(int pg, int ng);
    logic [NS-1:0] r = '0;
    int pr = 0, nr = 0;
    for (int s = 0; s < NS; s++) begin
      if (lm[s]) begin if (pr / mPs == pg) r[s] = 1'b1; pr++; end
      else       begin if (nr / mNs == ng) r[s] = 1'b1; nr++; end
    end
    return r;
  endfunction

  task automatic doStart(logic [NS-1:0] m, string req);
    @(negedge clk); start = 1'b1; prioMask = m;
    @(negedge clk); start = 1'b0;
    setModel(m);
    chk(prioGroup == 0 && normGroup == 0, req, "groups after start", {prioGroup, normGroup}, 0);
    chk(overrunWarn == (mGp > mGn), "R9", "overrunWarn", overrunWarn, (mGp > mGn));
  endtask

  // one complete step: compare requests, answer them, check move
  task automatic step(string req);
    logic [NS-1:0] e;
    bit wrap;
    e = expReq(epg, eng);
    chk(sectorReq == e, req, "sectorReq", sectorReq, e);
    chk(prioGroup == CW'(epg) && normGroup == CW'(eng), req, "group indices",
        {prioGroup, normGroup}, {CW'(epg), CW'(eng)});
    sectorDone = sectorReq;
    @(negedge clk); sectorDone = '0;
    wrap = (eng == mGn - 1);
    epg = (epg == mGp - 1) ? 0 : epg + 1;
    eng = wrap ? 0 : eng + 1;
    chk(cycleEnd == wrap, "R8", "cycleEnd", cycleEnd, wrap);
  endtask

  task automatic tReset;
    chk(sectorReq == '0, "R1", "reset sectorReq", sectorReq, 0);
    chk(prioGroup == 0 && normGroup == 0, "R1", "reset groups", {prioGroup, normGroup}, 0);
    chk(!cycleEnd && !overrunWarn, "R1", "reset flags", {cycleEnd, overrunWarn}, 0);
    sectorDone = '1;
    @(negedge clk); sectorDone = '0;
    chk(sectorReq == '0 && normGroup == 0, "R1", "idle before start", sectorReq, 0);
  endtask

  task automatic tSmallP;  // R2, R4: P=2 -> GP=1, GN=10
    logic [NS-1:0] m = '0;
    m[3] = 1; m[17] = 1;
    doStart(m, "R2");
    chk(mGn == 10 && mGp == 1, "R2", "model plan", mGn, 10);
    for (int i = 0; i < 11; i++) step("R2_R4");
  endtask

  task automatic tLargeP;  // R3, R7: P=6 -> GP=2, GN=12
    logic [NS-1:0] m = '0;
    m[0] = 1; m[5] = 1; m[9] = 1; m[12] = 1; m[20] = 1; m[29] = 1;
    doStart(m, "R3");
    chk(mGp == 2 && mGn == 12, "R3", "model plan", mGn, 12);
    for (int i = 0; i < 13; i++) step("R3_R7");
  endtask

  task automatic tAllP;  // R3, R9: P=30 -> GP=8, GN=1
    doStart('1, "R3");
    chk(overrunWarn == 1'b1, "R9", "warn with all priority", overrunWarn, 1);
    for (int i = 0; i < 9; i++) step("R3_R5");
  endtask

  task automatic tZeroP;  // R2: empty priority group, GN=6
    doStart('0, "R2");
    for (int i = 0; i < 7; i++) step("R2_R4");
  endtask

  task automatic tFourP;  // R2, R5: P=4 -> one normal slot, GN=26
    doStart(30'h0000_00F0, "R2");
    chk(mGn == 26, "R2", "model plan", mGn, 26);
    for (int i = 0; i < 27; i++) step("R2_R5");
  endtask

  task automatic tPartialDone;  // R6
    logic [NS-1:0] m = '0, e;
    m[3] = 1; m[17] = 1;
    doStart(m, "R6");
    e = expReq(0, 0);  // sectors 0,1,2,3,17
    sectorDone = '0; sectorDone[3] = 1; sectorDone[0] = 1; sectorDone[29] = 1;
    @(negedge clk); sectorDone = '0;
    chk(normGroup == 0 && sectorReq == e, "R6", "hold on partial done", normGroup, 0);
    sectorDone[10] = 1;  // stray, not requested
    @(negedge clk); sectorDone = '0;
    chk(normGroup == 0, "R6", "stray done ignored", normGroup, 0);
    sectorDone[17] = 1; sectorDone[1] = 1; sectorDone[2] = 1;
    @(negedge clk); sectorDone = '0;
    chk(normGroup == 1, "R6", "advance once all done", normGroup, 1);
    eng = 1;
    step("R6");
  endtask

  task automatic tMaskLatch;  // R10
    logic [NS-1:0] m = '0;
    m[8] = 1; m[22] = 1; m[25] = 1;
    doStart(m, "R10");
    prioMask = 30'h3FFF_0000;
    for (int i = 0; i < 3; i++) step("R10");
  endtask

  task automatic tRestart;  // R11
    logic [NS-1:0] m = '0;
    m[1] = 1;
    doStart(m, "R11");
    for (int i = 0; i < 3; i++) step("R11");
    m = '0; m[4] = 1; m[6] = 1; m[7] = 1; m[11] = 1; m[28] = 1;
    doStart(m, "R11");
    for (int i = 0; i < 2; i++) step("R11");
  endtask

  task automatic finish;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tSmallP();
    tLargeP();
    tAllP();
    tZeroP();
    tFourP();
    tPartialDone();
    tMaskLatch();
    tRestart();
    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end
endmodule